// File: doc/BRIEF.md
# Protected System Clock Control Register

This block is one 8-bit control register for a system clock generator. A CPU reaches it over a plain register bus: a write strobe, an address-match select, write data and combinational read data. The register drives four controls: a request to stop all clocks, a choice between the PLL clock and the main clock, a high/low oscillator drive-strength select, and the ratio by which the main clock is divided.

Several guards apply to writes. No write lands unless a separate unlock input is high. Power-management lock inputs freeze the stop and clock-select bits. The stop bit cannot be set together with the PLL clock or while oscillator-stop detection is enabled. The PLL clock cannot be chosen until a settle counter, started by a PLL enable input, has run out. If a guard keeps a bit that a write would have changed, the other bits of that write still land, and a sticky flag records the refusal. On stop-mode entry from a fast mode, and on a main-clock-off event in low-speed mode, the hardware forces drive strength high.

The interfaces are register-style and have no valid/ready streams. The bus has no back-pressure, and every write that passes the guards completes on the clock edge where it is presented.

Top module: `sysclk_ctl_reg`

## Requirements
- R1: After reset, `bus_rdata` reads 0x20, `pll_ready` is 0 and `wr_rejected` is 0. A write is presented when `bus_we` and `bus_sel` are both 1 at a rising clock edge. Its effect shows on `bus_rdata` and the control outputs from that edge on. When `bus_sel` is 0, the write changes nothing.
- R2: A write presented while `wr_unlock` is 0 is discarded completely.
- R3: Bit 0 is `stop_req` (1 = all clocks off). Bit 1 is `pll_sel` (1 = PLL clock, 0 = main clock). Bits 4:2 are reserved and always read 0, whatever value is written to them.
- R4: Bit 5 is `drive_hi`, where 1 means high drive strength and 0 means low. It takes the written value unless R10 forces it.
- R5: Bits 7:6 set `div_ratio`: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 16.
- R6: While `div_override` is 1, `div_ratio` equals the parameter OVR_DIV (default 8) in the same cycle, whatever bits 7:6 hold. Bits 7:6 are still stored and are used again once the override drops.
- R7: While `mod_lock` is 1, writes to bits 0 and 1 have no effect. While `wdt_lock` is 1, writes to bit 0 have no effect.
- R8: A write that would set bit 0 is refused if bit 1 is 1 after the same write, or if `osc_stop_det_en` is 1.
- R9: `pll_ready` rises after SETTLE_CYC consecutive clock edges with `pll_enable` high (default 16). It drops on the first edge after `pll_enable` goes low. A write that would set bit 1 while `pll_ready` is 0 leaves bit 1 at 0.
- R10: Bit 5 is forced to 1 when a write sets bit 0 from 0 to 1 while `low_speed` is 0. It is also forced to 1 at any edge where `main_off_evt` and `low_speed` are both 1.
- R11: When R7, R8 or R9 keeps a bit that the write would have changed, the other bits of the same write still update, and `wr_rejected` becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_sel | input | 1 | Address match for this register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Register read value |
| wr_unlock | input | 1 | Write protect enable; writes land only when 1 |
| mod_lock | input | 1 | Clock-modification lock (freezes bits 0 and 1) |
| wdt_lock | input | 1 | Watchdog on internal oscillator (freezes bit 0) |
| osc_stop_det_en | input | 1 | Oscillator-stop detection enabled |
| low_speed | input | 1 | System is in low-speed mode |
| main_off_evt | input | 1 | Main clock is being turned off this cycle |
| div_override | input | 1 | Divider override; bits 7:6 are ignored while 1 |
| pll_enable | input | 1 | PLL enabled; starts the settle counter |
| pll_ready | output | 1 | Settle time has elapsed |
| stop_req | output | 1 | All-clock stop request |
| pll_sel | output | 1 | 1 selects the PLL clock |
| drive_hi | output | 1 | High oscillator drive strength |
| div_ratio | output | 5 | Effective main clock divide ratio |
| wr_rejected | output | 1 | Sticky flag: a guarded bit refused a write |

## Verification
Every register result is due on the rising edge that samples the write or the event. `div_ratio` also follows `div_override` combinationally within the same cycle. The bench presents each stimulus 9 ns after a rising edge and lets exactly one edge pass. It then queues the expected value, computed from the requirements. A monitor compares it 5 ns after that edge, so a check never falls in a window where the inputs change. The PLL-ready check counts edges with `pll_enable` high and checks at SETTLE_CYC-1 edges and at SETTLE_CYC edges.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int REG_W   = 8;
  localparam int B_STOP  = 0;
  localparam int B_PLL   = 1;
  localparam int B_RSV_L = 2;
  localparam int B_RSV_H = 4;
  localparam int B_DRV   = 5;
  localparam int B_DIV_L = 6;
  localparam int B_DIV_H = 7;
  localparam logic [REG_W-1:0] RESET_VAL = 8'h20;

  typedef logic [REG_W-1:0] ctl_word_t;
endpackage

// File: rtl/sysclk_pll_settle.sv
module sysclk_pll_settle #(
  parameter int SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pll_enable,
  output logic pll_ready
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!pll_enable)    cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign pll_ready = (cnt_q == LIMIT);

  // R9: losing the enable drops readiness on the next edge
  assert_ready_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_enable |=> !pll_ready);

  // R9: readiness only appears while the PLL was enabled
  assert_ready_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_ready) |-> $past(pll_enable));
endmodule

// File: rtl/sysclk_div_decode.sv
module sysclk_div_decode #(
  parameter int RW      = 5,
  parameter int OVR_DIV = 8
) (
  input  logic [1:0]    div_code,
  input  logic          div_override,
  output logic [RW-1:0] div_ratio
);
  always_comb begin
    if (div_override) begin
      div_ratio = RW'(OVR_DIV);
    end else begin
      unique case (div_code)
        2'b00:   div_ratio = RW'(1);
        2'b01:   div_ratio = RW'(2);
        2'b10:   div_ratio = RW'(4);
        default: div_ratio = RW'(16);
      endcase
    end
  end
endmodule

// File: rtl/sysclk_wr_filter.sv
module sysclk_wr_filter
  import sysclk_pkg::*;
(
  input  ctl_word_t cur,
  input  ctl_word_t wdata,
  input  logic      wr_go,
  input  logic      mod_lock,
  input  logic      wdt_lock,
  input  logic      osc_stop_det_en,
  input  logic      pll_ready,
  input  logic      low_speed,
  input  logic      main_off_evt,
  output ctl_word_t nxt,
  output logic      reject
);
  always_comb begin
    nxt    = cur;
    reject = 1'b0;
    if (wr_go) begin
      nxt[B_DIV_H:B_DIV_L] = wdata[B_DIV_H:B_DIV_L];
      nxt[B_DRV]           = wdata[B_DRV];
      nxt[B_RSV_H:B_RSV_L] = '0;
      // clock select: lock, then settle guard
      if (wdata[B_PLL] != cur[B_PLL]) begin
        if (mod_lock || (wdata[B_PLL] && !pll_ready)) reject = 1'b1;
        else                                          nxt[B_PLL] = wdata[B_PLL];
      end
      // stop request: locks, then PLL / oscillator-stop detection guard
      if (wdata[B_STOP] != cur[B_STOP]) begin
        if (mod_lock || wdt_lock ||
            (wdata[B_STOP] && (nxt[B_PLL] || osc_stop_det_en)))
          reject = 1'b1;
        else
          nxt[B_STOP] = wdata[B_STOP];
      end
      // entering stop from a fast mode forces strong drive
      if (nxt[B_STOP] && !cur[B_STOP] && !low_speed) nxt[B_DRV] = 1'b1;
    end
    if (main_off_evt && low_speed) nxt[B_DRV] = 1'b1;
  end
endmodule

// File: rtl/sysclk_ctl_reg.sv
module sysclk_ctl_reg
  import sysclk_pkg::*;
#(
  parameter int SETTLE_CYC = 16,
  parameter int DIV_W      = 5,
  parameter int OVR_DIV    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic             bus_sel,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             wr_unlock,
  input  logic             mod_lock,
  input  logic             wdt_lock,
  input  logic             osc_stop_det_en,
  input  logic             low_speed,
  input  logic             main_off_evt,
  input  logic             div_override,
  input  logic             pll_enable,
  output logic             pll_ready,
  output logic             stop_req,
  output logic             pll_sel,
  output logic             drive_hi,
  output logic [DIV_W-1:0] div_ratio,
  output logic             wr_rejected
);
  ctl_word_t ctl_q, ctl_d;
  logic      wr_go, reject, rej_q;

  assign wr_go = bus_we && bus_sel && wr_unlock;

  sysclk_pll_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk        (clk),
    .rst_n      (rst_n),
    .pll_enable (pll_enable),
    .pll_ready  (pll_ready)
  );

  sysclk_wr_filter u_filter (
    .cur             (ctl_q),
    .wdata           (bus_wdata),
    .wr_go           (wr_go),
    .mod_lock        (mod_lock),
    .wdt_lock        (wdt_lock),
    .osc_stop_det_en (osc_stop_det_en),
    .pll_ready       (pll_ready),
    .low_speed       (low_speed),
    .main_off_evt    (main_off_evt),
    .nxt             (ctl_d),
    .reject          (reject)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= RESET_VAL;
      rej_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      rej_q <= rej_q | reject;
    end
  end

  sysclk_div_decode #(.RW(DIV_W), .OVR_DIV(OVR_DIV)) u_div (
    .div_code     (ctl_q[B_DIV_H:B_DIV_L]),
    .div_override (div_override),
    .div_ratio    (div_ratio)
  );

  assign bus_rdata   = {ctl_q[B_DIV_H:B_DRV], 3'b000, ctl_q[B_PLL:B_STOP]};
  assign stop_req    = ctl_q[B_STOP];
  assign pll_sel     = ctl_q[B_PLL];
  assign drive_hi    = ctl_q[B_DRV];
  assign wr_rejected = rej_q;

  // R2: without an unlocked, selected write or a drive event nothing moves
  assert_hold_when_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_we && bus_sel && wr_unlock) && !(main_off_evt && low_speed)) |=> $stable(bus_rdata));

  // R8: stop never begins together with the PLL or with stop detection armed
  assert_stop_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_req) |-> (!pll_sel && !$past(osc_stop_det_en)));

  // R9: PLL selection only after the settle counter finished
  assert_pll_after_settle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_sel) |-> $past(pll_ready));

  // R10: stop entry from a fast mode leaves drive strength high
  assert_drive_forced_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stop_req) && $past(!low_speed)) |-> drive_hi);

  // R11: the rejection flag is sticky
  assert_reject_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rejected |=> wr_rejected);
endmodule

// File: tb/sysclk_ctl_reg_tb.sv
`timescale 1ns/1ps
module sysclk_ctl_reg_tb;
  localparam int SETTLE = 16;
  localparam int OVR    = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 0, bus_sel = 0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic wr_unlock = 0, mod_lock = 0, wdt_lock = 0, osc_det = 0;
  logic low_speed = 0, main_off = 0, div_ovr = 0, pll_en = 0;
  logic pll_ready, stop_req, pll_sel, drive_hi, wr_rejected;
  logic [4:0] div_ratio;

  always #10 clk = ~clk;  // 50 MHz

  sysclk_ctl_reg #(.SETTLE_CYC(SETTLE), .DIV_W(5), .OVR_DIV(OVR)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wr_unlock(wr_unlock),
    .mod_lock(mod_lock), .wdt_lock(wdt_lock), .osc_stop_det_en(osc_det),
    .low_speed(low_speed), .main_off_evt(main_off), .div_override(div_ovr),
    .pll_enable(pll_en), .pll_ready(pll_ready), .stop_req(stop_req),
    .pll_sel(pll_sel), .drive_hi(drive_hi), .div_ratio(div_ratio),
    .wr_rejected(wr_rejected)
  );

  typedef struct {
    logic [7:0] rd;
    logic       rdy;
    logic       rej;
    logic [4:0] div;
    string      tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_bad = 0;

  // reference model state
  logic [7:0] m_reg = 8'h20;
  logic       m_rej = 1'b0;
  int         m_cnt = 0;

  function automatic logic [4:0] ref_div(logic [7:0] r, logic ovr);
    if (ovr) return 5'(OVR);
    case (r[7:6])
      2'b00:   return 5'd1;
      2'b01:   return 5'd2;
      2'b10:   return 5'd4;
      default: return 5'd16;
    endcase
  endfunction

  // driver: present stimulus now, let one edge pass, queue the expectation
  task automatic cyc(input logic we, input logic sel, input logic [7:0] w, input string tag);
    logic [7:0] n;
    logic       rdy, accept;
    bus_we = we; bus_sel = sel; bus_wdata = w;
    n = m_reg;
    rdy = (m_cnt == SETTLE);
    accept = we && sel && wr_unlock;
    if (accept) begin
      n = {w[7:5], 3'b000, m_reg[1:0]};
      if (w[1] != m_reg[1]) begin
        if (mod_lock || (w[1] && !rdy)) m_rej = 1'b1;
        else n[1] = w[1];
      end
      if (w[0] != m_reg[0]) begin
        if (mod_lock || wdt_lock || (w[0] && (n[1] || osc_det))) m_rej = 1'b1;
        else n[0] = w[0];
      end
      if (n[0] && !m_reg[0] && !low_speed) n[5] = 1'b1;
    end
    if (main_off && low_speed) n[5] = 1'b1;
    @(posedge clk);
    #1;
    bus_we = 0; bus_sel = 0; main_off = 0;
    m_reg = n;
    if (!pll_en) m_cnt = 0;
    else if (m_cnt < SETTLE) m_cnt = m_cnt + 1;
    q.push_back('{rd: m_reg, rdy: (m_cnt == SETTLE), rej: m_rej,
                  div: ref_div(m_reg, div_ovr), tag: tag});
    #8;
  endtask

  // monitor: compare each queued expectation 5 ns after its edge
  always @(posedge clk) begin
    #5;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (bus_rdata !== e.rd || stop_req !== e.rd[0] || pll_sel !== e.rd[1] ||
          drive_hi !== e.rd[5] || pll_ready !== e.rdy || wr_rejected !== e.rej ||
          div_ratio !== e.div) begin
        n_bad++;
        $display("FAIL %s: rd=%h rdy=%b rej=%b div=%0d stop=%b pll=%b drv=%b exp rd=%h rdy=%b rej=%b div=%0d",
                 e.tag, bus_rdata, pll_ready, wr_rejected, div_ratio, stop_req, pll_sel,
                 drive_hi, e.rd, e.rdy, e.rej, e.div);
      end
    end
  end

  logic done = 1'b0;
  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #9 rst_n = 1'b1;
    cyc(0, 0, 8'h00, "R1 reset state");
    wr_unlock = 0;
    cyc(1, 1, 8'hC0, "R2 write while protected");
    wr_unlock = 1;
    cyc(1, 1, 8'h40, "R4 R5 drive low, divide by 2");
    cyc(1, 1, 8'h80, "R5 divide by 4");
    cyc(1, 1, 8'hC0, "R5 divide by 16");
    cyc(1, 1, 8'h00, "R5 no division");
    div_ovr = 1;
    cyc(1, 1, 8'hC0, "R6 override active");
    div_ovr = 0;
    cyc(0, 0, 8'h00, "R6 override released");
    cyc(1, 1, 8'hFC, "R3 reserved bits read zero");
    cyc(1, 1, 8'h22, "R9 R11 PLL select before settle");
    cyc(1, 0, 8'hFF, "R1 unselected write");
    pll_en = 1;
    for (int i = 0; i < SETTLE - 1; i++) cyc(0, 0, 8'h00, "R9 settling");
    cyc(0, 0, 8'h00, "R9 settle complete");
    cyc(1, 1, 8'h02, "R9 PLL select after settle");
    cyc(1, 1, 8'h03, "R8 stop with PLL selected");
    cyc(1, 1, 8'h00, "R3 back to main clock");
    osc_det = 1;
    cyc(1, 1, 8'h01, "R8 stop with stop detection");
    osc_det = 0;
    mod_lock = 1;
    cyc(1, 1, 8'h42, "R7 R11 modification lock");
    mod_lock = 0;
    wdt_lock = 1;
    cyc(1, 1, 8'h81, "R7 R11 watchdog lock");
    wdt_lock = 0;
    cyc(1, 1, 8'h01, "R10 stop from fast mode");
    cyc(1, 1, 8'h00, "R3 clear stop");
    low_speed = 1;
    cyc(1, 1, 8'h01, "R10 stop in low speed, no force");
    cyc(1, 1, 8'h00, "R4 clear");
    main_off = 1;
    cyc(0, 0, 8'h00, "R10 main clock off in low speed");
    low_speed = 0;
    pll_en = 0;
    cyc(0, 0, 8'h00, "R9 ready drops");
    @(posedge clk); #8;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule